// File: doc/BRIEF.md
# Redistributor Sleep/Wake Handshake Controller

This block sits between one processor core and the per-core part of an interrupt redistributor. It runs the handshake that lets the core power down safely. The core writes a single sleep-request bit through a small register port and reads back two values: the request bit and an asleep status bit. Interrupts that are pending for the core enter a small in-order pending queue. While the core is awake, the head of that queue is offered to the core on a valid/ready delivery port.

When the core sets the request bit, delivery to the core stops at once. Everything still queued, and anything that arrives later, is sent out on a separate forwarding port, so that other logic can take over the work. The asleep status rises only after the queue is empty and no new interrupt is arriving. Only then may the core cut its power.

Clearing the request bit wakes the block. The asleep status falls one cycle later, and delivery to the core resumes in the cycle after that. If the request is withdrawn before the drain finishes, the block goes straight back to normal delivery and never reports asleep.

Top module: `rdist_sleep_ctrl`

## Requirements
- R1: After a synchronous reset, the request readback is 0, asleep is 0, the core and forwarding valids are both 0, and pend_ready_o is 1.
- R2: A cycle with cfg_wr_en_i high loads cfg_wr_sleep_i into the request bit. The new value appears on cfg_sleep_req_o in the following cycle.
- R3: While the request bit is 0 and the block is awake, queued interrupts are offered on the core port in arrival order. One entry leaves for each cycle in which core_valid_o and core_ready_i are both high, and fwd_valid_o stays 0.
- R4: From the cycle after the request bit is set until delivery resumes, core_valid_o is 0 and queued entries leave in arrival order on the forwarding port.
- R5: Asleep rises only after the pending queue has been empty, with no arrival, for one clock edge while draining. If forwarding is stalled with entries queued, asleep stays 0.
- R6: If the request bit is cleared while draining, the block returns to awake one cycle later without ever raising asleep. Entries still queued are then offered on the core port.
- R7: When the request bit is cleared while asleep, asleep is still 1 in the next cycle and falls in the cycle after that. core_valid_o may rise one cycle after asleep falls, and not earlier.
- R8: While asleep, an arriving interrupt leaves asleep at 1 and is presented on the forwarding port in the cycle after it is accepted.
- R9: The queue holds DEPTH entries. pend_ready_o is 0 when the queue is full, and an interrupt offered then is discarded and never appears on either output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en_i | input | 1 | Register write strobe for the request bit |
| cfg_wr_sleep_i | input | 1 | Value written to the request bit |
| cfg_sleep_req_o | output | 1 | Readback of the request bit |
| cfg_asleep_o | output | 1 | Asleep status, core may power down when 1 |
| pend_valid_i | input | 1 | A pending interrupt is offered |
| pend_id_i | input | PEND_ID_W | Identifier of the offered interrupt |
| pend_ready_o | output | 1 | Queue can accept an interrupt |
| core_valid_o | output | 1 | Interrupt offered to the core |
| core_id_o | output | PEND_ID_W | Identifier offered to the core |
| core_ready_i | input | 1 | Core takes the offered interrupt |
| fwd_valid_o | output | 1 | Interrupt offered on the forwarding port |
| fwd_id_o | output | PEND_ID_W | Identifier offered on the forwarding port |
| fwd_ready_i | input | 1 | Forwarding side takes the offered interrupt |

## Verification
A wrong power state shows at the ports within one or two cycles. Asleep may rise while entries are still queued. An interrupt may reach the core after the request was written, or turn up on the forwarding port while the core is awake. A wrong wake sequence shows as asleep falling in the wrong cycle, or as delivery to the core resuming too early relative to the asleep status. Queue faults show as lost, reordered or duplicated identifiers on whichever port is active, or as a discarded interrupt turning up later.

// File: rtl/rdist_sleep_pkg.sv
package rdist_sleep_pkg;

    localparam int PEND_ID_W = 10;

    typedef logic [PEND_ID_W-1:0] pend_id_t;

    typedef enum logic [1:0] {
        PS_AWAKE  = 2'd0,
        PS_DRAIN  = 2'd1,
        PS_ASLEEP = 2'd2,
        PS_WAKE   = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic     valid;
        pend_id_t id;
    } pend_beat_t;

    // Next power state from the current state, the request bit and the drain condition
    function automatic pwr_state_e pwr_next(pwr_state_e cur, logic req, logic drained);
        pwr_state_e nxt;
        nxt = cur;
        unique case (cur)
            PS_AWAKE:  if (req) nxt = PS_DRAIN;
            PS_DRAIN: begin
                if (!req)         nxt = PS_AWAKE;
                else if (drained) nxt = PS_ASLEEP;
            end
            PS_ASLEEP: if (!req) nxt = PS_WAKE;
            PS_WAKE:   nxt = PS_AWAKE;
            default:   nxt = PS_AWAKE;
        endcase
        return nxt;
    endfunction

    // Pending work goes to the core only when awake and no request is standing
    function automatic logic route_to_core(pwr_state_e cur, logic req);
        return (cur == PS_AWAKE) && !req;
    endfunction

endpackage

// File: rtl/rdist_req_reg.sv
module rdist_req_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en_i,
    input  logic wr_data_i,
    output logic req_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)          req_q <= 1'b0;
        else if (wr_en_i) req_q <= wr_data_i;
    end

    assign req_o = req_q;

    // R2
    req_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (req_o == $past(wr_data_i)));

endmodule

// File: rtl/rdist_pend_fifo.sv
module rdist_pend_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] adv(logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= adv(wr_q);
            if (do_pop)  rd_q <= adv(rd_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= data_i;
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full_o && !pop_i) |=> full_o);

    // R3
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);

endmodule

// File: rtl/rdist_pwr_fsm.sv
module rdist_pwr_fsm
    import rdist_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       drained_i,
    output pwr_state_e state_o,
    output logic       asleep_o
);
    pwr_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_AWAKE;
        else     state_q <= pwr_next(state_q, req_i, drained_i);
    end

    assign state_o  = state_q;
    assign asleep_o = (state_q == PS_ASLEEP);

    // R5
    asleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == PS_ASLEEP) |-> $past(drained_i));

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_DRAIN && !req_i) |=> (state_q == PS_AWAKE));

    // R7
    wake_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_ASLEEP && !req_i) |=> (state_q == PS_WAKE));

    // R7
    wake_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAKE) |=> (state_q == PS_AWAKE));

endmodule

// File: rtl/rdist_out_steer.sv
module rdist_out_steer
    import rdist_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_state_e state_i,
    input  logic       req_i,
    input  logic       empty_i,
    input  pend_id_t   head_id_i,
    input  logic       core_ready_i,
    input  logic       fwd_ready_i,
    output pend_beat_t core_o,
    output pend_beat_t fwd_o,
    output logic       pop_o
);
    logic to_core;

    assign to_core      = route_to_core(state_i, req_i);
    assign core_o.valid = !empty_i && to_core;
    assign core_o.id    = head_id_i;
    assign fwd_o.valid  = !empty_i && !to_core;
    assign fwd_o.id     = head_id_i;
    assign pop_o        = (core_o.valid && core_ready_i) || (fwd_o.valid && fwd_ready_i);

    // R4
    core_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state_i != PS_AWAKE) |-> !core_o.valid);

    // R3
    fwd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (state_i == PS_AWAKE && !req_i) |-> !fwd_o.valid);

endmodule

// File: rtl/rdist_sleep_ctrl.sv
module rdist_sleep_ctrl
    import rdist_sleep_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en_i,
    input  logic                 cfg_wr_sleep_i,
    output logic                 cfg_sleep_req_o,
    output logic                 cfg_asleep_o,
    input  logic                 pend_valid_i,
    input  logic [PEND_ID_W-1:0] pend_id_i,
    output logic                 pend_ready_o,
    output logic                 core_valid_o,
    output logic [PEND_ID_W-1:0] core_id_o,
    input  logic                 core_ready_i,
    output logic                 fwd_valid_o,
    output logic [PEND_ID_W-1:0] fwd_id_o,
    input  logic                 fwd_ready_i
);
    logic       req;
    logic       empty, full, pop, drained;
    pend_id_t   head_id;
    pwr_state_e state;
    pend_beat_t core_b, fwd_b;

    rdist_req_reg u_req (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (cfg_wr_en_i),
        .wr_data_i (cfg_wr_sleep_i),
        .req_o     (req)
    );

    rdist_pend_fifo #(.DEPTH(DEPTH), .W(PEND_ID_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (pend_valid_i),
        .data_i  (pend_id_i),
        .pop_i   (pop),
        .data_o  (head_id),
        .empty_o (empty),
        .full_o  (full)
    );

    assign drained = empty && !pend_valid_i;

    rdist_pwr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .drained_i (drained),
        .state_o   (state),
        .asleep_o  (cfg_asleep_o)
    );

    rdist_out_steer u_steer (
        .clk          (clk),
        .rst          (rst),
        .state_i      (state),
        .req_i        (req),
        .empty_i      (empty),
        .head_id_i    (head_id),
        .core_ready_i (core_ready_i),
        .fwd_ready_i  (fwd_ready_i),
        .core_o       (core_b),
        .fwd_o        (fwd_b),
        .pop_o        (pop)
    );

    assign cfg_sleep_req_o = req;
    assign pend_ready_o    = !full;
    assign core_valid_o    = core_b.valid;
    assign core_id_o       = core_b.id;
    assign fwd_valid_o     = fwd_b.valid;
    assign fwd_id_o        = fwd_b.id;

    // R8
    asleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_asleep_o && cfg_sleep_req_o) |=> cfg_asleep_o);

    // R5
    asleep_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_asleep_o) |-> !core_valid_o);

endmodule

// File: tb/rdist_sleep_ctrl_tb.sv
module rdist_sleep_ctrl_tb_top;
    localparam int DEPTH = 4;
    localparam int IW    = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr_en_i = 1'b0, cfg_wr_sleep_i = 1'b0;
    logic          cfg_sleep_req_o, cfg_asleep_o;
    logic          pend_valid_i = 1'b0;
    logic [IW-1:0] pend_id_i = '0;
    logic          pend_ready_o;
    logic          core_valid_o, core_ready_i = 1'b0;
    logic [IW-1:0] core_id_o;
    logic          fwd_valid_o, fwd_ready_i = 1'b0;
    logic [IW-1:0] fwd_id_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rdist_sleep_ctrl #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_sleep(logic v);
        cfg_wr_en_i = 1'b1;
        cfg_wr_sleep_i = v;
        step();
        cfg_wr_en_i = 1'b0;
    endtask

    task automatic push(int id);
        pend_valid_i = 1'b1;
        pend_id_i = IW'(id);
        step();
        pend_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req", int'(cfg_sleep_req_o), 0);
        chk("R1 asleep", int'(cfg_asleep_o), 0);
        chk("R1 core_valid", int'(core_valid_o), 0);
        chk("R1 fwd_valid", int'(fwd_valid_o), 0);
        chk("R1 pend_ready", int'(pend_ready_o), 1);
    endtask

    task automatic t_awake_order();
        push(5); push(6); push(7);
        chk("R3 core_valid", int'(core_valid_o), 1);
        chk("R3 fwd_valid", int'(fwd_valid_o), 0);
        core_ready_i = 1'b1;
        chk("R3 id0", int'(core_id_o), 5);
        step();
        chk("R3 id1", int'(core_id_o), 6);
        step();
        chk("R3 id2", int'(core_id_o), 7);
        step();
        chk("R3 empty", int'(core_valid_o), 0);
        core_ready_i = 1'b0;
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(20 + i);
        chk("R9 ready_low", int'(pend_ready_o), 0);
        push(99);
        core_ready_i = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R9 order", int'(core_id_o), 20 + i);
            step();
        end
        chk("R9 discarded", int'(core_valid_o), 0);
        chk("R9 ready_back", int'(pend_ready_o), 1);
        core_ready_i = 1'b0;
    endtask

    task automatic t_sleep_drain();
        push(11); push(12);
        wr_sleep(1'b1);
        chk("R2 req_read", int'(cfg_sleep_req_o), 1);
        chk("R4 core_gated", int'(core_valid_o), 0);
        chk("R4 fwd_valid", int'(fwd_valid_o), 1);
        for (int i = 0; i < 4; i++) step();
        chk("R5 stalled_awake", int'(cfg_asleep_o), 0);
        fwd_ready_i = 1'b1;
        chk("R4 fwd_id0", int'(fwd_id_o), 11);
        step();
        chk("R4 fwd_id1", int'(fwd_id_o), 12);
        step();
        chk("R5 empty_not_yet", int'(cfg_asleep_o), 0);
        step();
        chk("R5 asleep", int'(cfg_asleep_o), 1);
        fwd_ready_i = 1'b0;
    endtask

    task automatic t_asleep_arrival();
        push(33);
        chk("R8 asleep_kept", int'(cfg_asleep_o), 1);
        chk("R8 fwd_valid", int'(fwd_valid_o), 1);
        chk("R8 fwd_id", int'(fwd_id_o), 33);
        chk("R8 core_gated", int'(core_valid_o), 0);
        fwd_ready_i = 1'b1;
        step();
        fwd_ready_i = 1'b0;
        chk("R8 still_asleep", int'(cfg_asleep_o), 1);
    endtask

    task automatic t_wake();
        push(44);
        wr_sleep(1'b0);
        chk("R7 req_clear", int'(cfg_sleep_req_o), 0);
        chk("R7 asleep_one_more", int'(cfg_asleep_o), 1);
        step();
        chk("R7 asleep_drop", int'(cfg_asleep_o), 0);
        chk("R7 core_not_yet", int'(core_valid_o), 0);
        step();
        chk("R7 core_resume", int'(core_valid_o), 1);
        chk("R7 core_id", int'(core_id_o), 44);
        core_ready_i = 1'b1;
        step();
        core_ready_i = 1'b0;
        chk("R7 drained", int'(core_valid_o), 0);
    endtask

    task automatic t_abort();
        int seen = 0;
        push(51); push(52);
        wr_sleep(1'b1);
        for (int i = 0; i < 3; i++) begin
            if (cfg_asleep_o) seen = 1;
            step();
        end
        wr_sleep(1'b0);
        if (cfg_asleep_o) seen = 1;
        chk("R6 fwd_in_abort", int'(fwd_valid_o), 1);
        step();
        if (cfg_asleep_o) seen = 1;
        chk("R6 never_asleep", seen, 0);
        chk("R6 core_back", int'(core_valid_o), 1);
        chk("R6 core_id", int'(core_id_o), 51);
        core_ready_i = 1'b1;
        step(); step();
        core_ready_i = 1'b0;
        chk("R6 empty", int'(core_valid_o), 0);
    endtask

    initial begin
        step(); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_awake_order();
        t_full();
        t_sleep_drain();
        t_asleep_arrival();
        t_wake();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule